// File: doc/BRIEF.md
# Edge-Aligned PWM Generator with Fractional Tick Divider

This block produces one pulse-width-modulated output from a 16-bit duty command. A fixed-point clock divider (integer part plus a 4-bit fraction) turns the system clock into count ticks. A period counter advances on each tick from zero up to a programmable wrap limit and then returns to zero. The output is high while the count is below a compare threshold. That threshold is derived from the duty command by a rounding scaler.

The scaler maps the top duty code to a threshold one above the wrap limit, so full scale gives an output that never drops. The wrap limit is capped one below the counter's all-ones value so that this threshold still fits the counter width. Software-style writes go through a single write port that selects the wrap limit, the divider, or the duty. New wrap and threshold values are held back until the period in progress ends, so no period is ever cut short. An enable input starts and stops the generator.

Top module: `pwm_slice`

## Requirements
- R1: With a tick every cycle, the counter visits 0,1,...,L and then returns to 0, so one period is L+1 ticks, where L is the active wrap limit.
- R2: A compare threshold of 0 keeps `pwm_out` low for the whole period.
- R3: A duty command of 65535 sets the threshold to L+1 (saturated at 65535), and `pwm_out` then stays high for every cycle of every period.
- R4: For any threshold T, `pwm_out` is high exactly while the count is below T. With L=9 and T=5 the output is high for 5 of every 10 ticks.
- R5: Writing `wr_sel`=0 loads the wrap limit. A written value above 65534 is stored as 65534.
- R6: Writing `wr_sel`=1 loads the divider as a 12-bit fixed-point value whose integer part is the value divided by 16 and whose fraction is the value modulo 16. A written value above 4095 is stored as 4095.
- R7: Each tick interval lasts either I or I+1 clock cycles. A 4-bit accumulator adds the fraction on every tick, and the interval after a carry is the longer one. The first interval after enable is I cycles. An integer part of 0 behaves as 1.
- R8: Writing `wr_sel`=2 loads the duty command D. When D is below 65535, the threshold is floor((D*L + 32767) / 65534), computed without overflow.
- R9: A write of the wrap limit or the duty changes neither the active wrap limit nor the active threshold until the current period ends, or until enable is low.
- R10: While `en` is low, `pwm_out` is low and the counter and divider are held at zero. The first cycle after `en` rises shows count 0.
- R11: After reset, the wrap limit is 65534, the divider is 1.0 (stored value 16), the duty is 0, and `pwm_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds counter and divider at zero |
| wr_en | input | 1 | Write strobe for the setting selected by `wr_sel` |
| wr_sel | input | 2 | 0 wrap limit, 1 divider, 2 duty, 3 unused |
| wr_data | input | 16 | Write value |
| pwm_out | output | 1 | Modulated output |

## Verification
A write lands on the clock edge that samples it. It reaches `pwm_out` only at the edge that ends the current period, or at the first edge with `en` low, and never earlier. `en` gates the output in the same cycle it changes. Counter and divider state changes show on the output one edge later. The bench drives inputs just after a rising edge and samples the output at the falling edge. Its reference model steps once per rising edge under the same rules, so every cycle's expected output is defined. Measured high-cycle counts are taken over windows that start at a known phase, just after an enable restart.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int CNT_W_DEF      = 16;
    localparam int DIV_INT_W_DEF  = 8;
    localparam int DIV_FRAC_W_DEF = 4;

    typedef enum logic [1:0] {
        WSEL_LIMIT   = 2'd0,
        WSEL_DIVIDER = 2'd1,
        WSEL_DUTY    = 2'd2,
        WSEL_SPARE   = 2'd3
    } wsel_e;

    typedef enum logic [1:0] {
        CTR_IDLE,
        CTR_RUN,
        CTR_WRAP
    } ctr_phase_e;

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
    import pwm_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int INT_W  = DIV_INT_W_DEF,
    parameter int FRAC_W = DIV_FRAC_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [1:0]              wr_sel,
    input  logic [CNT_W-1:0]        wr_data,
    output logic [CNT_W-1:0]        limit_q,
    output logic [INT_W+FRAC_W-1:0] div_q,
    output logic [CNT_W-1:0]        duty_q
);
    localparam int DW = INT_W + FRAC_W;
    localparam logic [CNT_W-1:0] LIMIT_MAX = CNT_W'((2 ** CNT_W) - 2);
    localparam logic [CNT_W-1:0] DIV_MAX_W = CNT_W'((2 ** DW) - 1);
    localparam logic [DW-1:0]    DIV_ONE   = DW'(2 ** FRAC_W);

    wsel_e sel;
    assign sel = wsel_e'(wr_sel);

    logic [CNT_W-1:0] limit_in;
    logic [DW-1:0]    div_in;

    always_comb begin
        limit_in = (wr_data > LIMIT_MAX) ? LIMIT_MAX : wr_data;
        div_in   = (wr_data > DIV_MAX_W) ? DW'(DIV_MAX_W) : DW'(wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q <= LIMIT_MAX;
            div_q   <= DIV_ONE;
            duty_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                WSEL_LIMIT:   limit_q <= limit_in;
                WSEL_DIVIDER: div_q   <= div_in;
                WSEL_DUTY:    duty_q  <= wr_data;
                default:      ;
            endcase
        end
    end
endmodule

// File: rtl/pwm_frac_div.sv
module pwm_frac_div
    import pwm_pkg::*;
#(
    parameter int INT_W  = DIV_INT_W_DEF,
    parameter int FRAC_W = DIV_FRAC_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [INT_W+FRAC_W-1:0] div,
    output logic                    tick
);
    localparam int DW = INT_W + FRAC_W;
    localparam int CW = INT_W + 1;
    localparam logic [CW-1:0] ONE_C = CW'(1);

    logic [INT_W-1:0]  int_part;
    logic [FRAC_W-1:0] frac_part;
    logic [CW-1:0]     eff_int;
    logic [CW-1:0]     limit;
    logic [CW-1:0]     dcnt_q;
    logic [FRAC_W-1:0] acc_q;
    logic              long_q;
    logic [FRAC_W:0]   acc_sum;

    assign int_part  = div[DW-1:FRAC_W];
    assign frac_part = div[FRAC_W-1:0];

    always_comb begin
        eff_int = (int_part == '0) ? ONE_C : {1'b0, int_part};
        limit   = eff_int - ONE_C + {{(CW-1){1'b0}}, long_q};
        acc_sum = {1'b0, acc_q} + {1'b0, frac_part};
        tick    = en && (dcnt_q >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            dcnt_q <= '0;
            acc_q  <= '0;
            long_q <= 1'b0;
        end else if (tick) begin
            dcnt_q <= '0;
            acc_q  <= acc_sum[FRAC_W-1:0];
            long_q <= acc_sum[FRAC_W];
        end else begin
            dcnt_q <= dcnt_q + ONE_C;
        end
    end
endmodule

// File: rtl/pwm_duty_scale.sv
module pwm_duty_scale
    import pwm_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic [CNT_W-1:0] duty,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] thresh
);
    localparam int PW = 2 * CNT_W + 1;
    localparam logic [CNT_W-1:0] FULL   = '1;
    localparam logic [PW-1:0]    DENOM  = PW'((2 ** CNT_W) - 2);
    localparam logic [PW-1:0]    HALF   = PW'(((2 ** CNT_W) - 2) / 2);
    localparam logic [CNT_W:0]   ONE_X  = (CNT_W + 1)'(1);
    localparam logic [CNT_W:0]   FULL_X = {1'b0, FULL};

    logic [PW-1:0]  prod;
    logic [PW-1:0]  quo;
    logic [CNT_W:0] above;

    always_comb begin
        prod  = PW'(duty) * PW'(limit) + HALF;
        quo   = prod / DENOM;
        above = {1'b0, limit} + ONE_X;
        if (duty == FULL) begin
            thresh = (above > FULL_X) ? FULL : CNT_W'(above);
        end else begin
            thresh = CNT_W'(quo);
        end
    end
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
    import pwm_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit_stg,
    input  logic [CNT_W-1:0] thresh_stg,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] act_limit,
    output logic [CNT_W-1:0] act_thresh,
    output logic             wrap,
    output logic             pwm_out
);
    localparam logic [CNT_W-1:0] LIMIT_MAX = CNT_W'((2 ** CNT_W) - 2);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    ctr_phase_e phase;

    always_comb begin
        if (!en)                        phase = CTR_IDLE;
        else if (tick && cnt == act_limit) phase = CTR_WRAP;
        else                            phase = CTR_RUN;
        wrap    = (phase == CTR_WRAP);
        pwm_out = en && (cnt < act_thresh);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            act_limit  <= LIMIT_MAX;
            act_thresh <= '0;
        end else begin
            case (phase)
                CTR_IDLE, CTR_WRAP: begin
                    cnt        <= '0;
                    act_limit  <= limit_stg;
                    act_thresh <= thresh_stg;
                end
                default: begin
                    if (tick) cnt <= cnt + ONE;
                end
            endcase
        end
    end
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
    import pwm_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int INT_W  = DIV_INT_W_DEF,
    parameter int FRAC_W = DIV_FRAC_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out
);
    localparam int DW = INT_W + FRAC_W;

    logic [CNT_W-1:0] limit_q;
    logic [DW-1:0]    div_q;
    logic [CNT_W-1:0] duty_q;
    logic [CNT_W-1:0] thresh;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] act_limit;
    logic [CNT_W-1:0] act_thresh;
    logic             wrap;

    pwm_cfg_regs #(.CNT_W(CNT_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .limit_q(limit_q), .div_q(div_q), .duty_q(duty_q)
    );

    pwm_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
        .clk(clk), .rst(rst), .en(en), .div(div_q), .tick(tick)
    );

    pwm_duty_scale #(.CNT_W(CNT_W)) u_scale (
        .duty(duty_q), .limit(limit_q), .thresh(thresh)
    );

    pwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst(rst), .en(en), .tick(tick),
        .limit_stg(limit_q), .thresh_stg(thresh),
        .cnt(cnt), .act_limit(act_limit), .act_thresh(act_thresh),
        .wrap(wrap), .pwm_out(pwm_out)
    );
endmodule

// File: rtl/pwm_slice_chk.sv
module pwm_slice_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             tick,
    input logic             wrap,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] act_limit,
    input logic [CNT_W-1:0] act_thresh,
    input logic             pwm_out
);
    localparam logic [CNT_W-1:0] LIMIT_MAX = CNT_W'((2 ** CNT_W) - 2);
    localparam logic [CNT_W:0]   ONE_X     = (CNT_W + 1)'(1);

    // R10: disabled output is low
    a_r10_off_low: assert property (@(posedge clk) disable iff (rst)
        !en |-> !pwm_out);

    // R2: zero threshold never drives high
    a_r2_zero_low: assert property (@(posedge clk) disable iff (rst)
        (act_thresh == '0) |-> !pwm_out);

    // R3: threshold one above the limit keeps the output high
    a_r3_full_high: assert property (@(posedge clk) disable iff (rst)
        (en && ({1'b0, act_thresh} == {1'b0, act_limit} + ONE_X)) |-> pwm_out);

    // R1: the end of a period returns the count to zero
    a_r1_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0));

    // R1: a tick inside a period advances the count by one
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        (en && tick && !wrap) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R5: active limit never exceeds the cap
    a_r5_limit_cap: assert property (@(posedge clk) disable iff (rst)
        act_limit <= LIMIT_MAX);

    // R9: active settings change only at a wrap or while disabled
    a_r9_thresh_staged: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_thresh) |-> $past(rst || !en || wrap));

    a_r9_limit_staged: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_limit) |-> $past(rst || !en || wrap));
endmodule

bind pwm_slice pwm_slice_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .wrap(wrap), .cnt(cnt),
    .act_limit(act_limit), .act_thresh(act_thresh), .pwm_out(pwm_out)
);

// File: tb/sim_pwm_slice.sv
`timescale 1ns/1ps
module sim_pwm_slice;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        pwm_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwm_slice u0 (
        .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pwm_out(pwm_out)
    );

    // ---------------- reference model ----------------
    int m_lim, m_div, m_duty;
    int m_dcnt, m_acc, m_long;
    int m_cnt, m_alim, m_athr;

    function automatic int scale(input int d, input int l);
        longint p;
        if (d == 65535) return (l + 1 > 65535) ? 65535 : l + 1;
        p = longint'(d) * longint'(l) + 64'd32767;
        return int'(p / 65534);
    endfunction

    always @(posedge clk) begin
        int thr, ipart, frac, lim;
        bit tk;
        thr = scale(m_duty, m_lim);
        if (rst) begin
            m_lim = 65534; m_div = 16; m_duty = 0;
            m_dcnt = 0; m_acc = 0; m_long = 0;
            m_cnt = 0; m_alim = 65534; m_athr = 0;
        end else begin
            if (!en) begin
                m_dcnt = 0; m_acc = 0; m_long = 0;
                m_cnt = 0; m_alim = m_lim; m_athr = thr;
            end else begin
                ipart = m_div / 16;
                frac  = m_div % 16;
                if (ipart == 0) ipart = 1;
                lim = ipart - 1 + m_long;
                tk = (m_dcnt >= lim);
                if (tk) begin
                    m_dcnt = 0;
                    m_acc  = m_acc + frac;
                    m_long = (m_acc >= 16) ? 1 : 0;
                    m_acc  = m_acc % 16;
                    if (m_cnt == m_alim) begin
                        m_cnt = 0; m_alim = m_lim; m_athr = thr;
                    end else begin
                        m_cnt = m_cnt + 1;
                    end
                end else begin
                    m_dcnt = m_dcnt + 1;
                end
            end
            if (wr_en) begin
                case (wr_sel)
                    2'd0: m_lim  = (wr_data > 16'd65534) ? 65534 : int'(wr_data);
                    2'd1: m_div  = (wr_data > 16'd4095) ? 4095 : int'(wr_data);
                    2'd2: m_duty = int'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R4: cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        int e;
        if (!rst && !done) begin
            e = (en && (m_cnt < m_athr)) ? 1 : 0;
            check(int'(pwm_out) == e, "R4 per-cycle", int'(pwm_out), e);
        end
    end

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic restart();
        @(posedge clk); #1; en = 1'b0;
        @(posedge clk); #1; en = 1'b1;
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) h++;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        done = 1'b1;
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int h;
        repeat (4) @(posedge clk);
        #1;
        @(negedge clk);
        check(pwm_out == 1'b0, "R11 reset output", int'(pwm_out), 0);
        @(posedge clk); #1; rst = 1'b0;

        // R11 / R2: default duty 0 keeps output low while running
        en = 1'b1;
        count_high(20, h);
        check(h == 0, "R2 default zero duty", h, 0);

        // R11 / R3: default limit 65534 with full duty stays high
        wr(2'd2, 16'hFFFF);
        restart();
        count_high(20, h);
        check(h == 20, "R11 default limit full duty", h, 20);

        // R1 / R4: limit 9, half duty -> threshold 5
        wr(2'd0, 16'd9);
        wr(2'd2, 16'd32767);
        restart();
        count_high(100, h);
        check(h == 50, "R4 half duty over 10 periods", h, 50);

        // R3: full scale on a short period
        wr(2'd2, 16'hFFFF);
        restart();
        count_high(100, h);
        check(h == 100, "R3 full scale", h, 100);

        // R8: rounding, limit 2
        wr(2'd0, 16'd2);
        wr(2'd2, 16'd16384);
        restart();
        count_high(30, h);
        check(h == 10, "R8 rounds up to 1", h, 10);
        wr(2'd2, 16'd16383);
        restart();
        count_high(30, h);
        check(h == 0, "R8 rounds down to 0", h, 0);

        // R7: fraction 2.5, limit 3, threshold 1
        wr(2'd0, 16'd3);
        wr(2'd1, 16'd40);
        wr(2'd2, 16'd10923);
        restart();
        count_high(19, h);
        check(h == 5, "R7 fractional spacing", h, 5);

        // R7: integer part 0 behaves as 1, fraction 0.5
        wr(2'd0, 16'd1);
        wr(2'd1, 16'd8);
        wr(2'd2, 16'd32767);
        restart();
        count_high(6, h);
        check(h == 4, "R7 zero integer part", h, 4);

        // R6: divider write above 4095 clamps to 255 + 15/16
        wr(2'd1, 16'd4096);
        restart();
        count_high(256, h);
        check(h == 255, "R6 divider clamp", h, 255);

        // R9: a duty write mid-period waits for the wrap
        wr(2'd1, 16'd16);
        wr(2'd0, 16'd9);
        wr(2'd2, 16'd32767);
        restart();
        @(posedge clk); #1;
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'hFFFF;
        @(posedge clk); #1;
        wr_en = 1'b0;
        count_high(7, h);
        check(h == 2, "R9 old threshold kept", h, 2);
        count_high(10, h);
        check(h == 10, "R9 new threshold at wrap", h, 10);

        // R10: disabled output low, restart from zero
        @(posedge clk); #1; en = 1'b0;
        count_high(20, h);
        check(h == 0, "R10 disabled low", h, 0);
        wr(2'd2, 16'd32767);
        @(posedge clk); #1; en = 1'b1;
        count_high(5, h);
        check(h == 5, "R10 restart at count 0", h, 5);

        // R5: limit write above 65534 clamps; threshold 32768 of 65535
        wr(2'd0, 16'hFFFF);
        wr(2'd2, 16'd32768);
        restart();
        count_high(65535, h);
        check(h == 32768, "R5 limit clamp", h, 32768);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule